// File: doc/BRIEF.md
# Elapsed Cycle Count Encoder

This block measures how many clock cycles pass while control-transfer recording is active, and hands that measurement to each new transfer record as a compact floating-point style field plus a valid flag. It counts only while recording is active, which means the current privilege mode is enabled for recording and recording is not frozen. Each qualified transfer captures the current measurement and starts a new one. A buffer write path elsewhere takes the packed field and the flag into the record it is building.

Two kinds of event affect the measurement. A write to the recording control register and a clear command both zero the count and mark the next record's count as untrustworthy. A separate invalidate input marks the count as untrustworthy without zeroing it. This input is for implementation-specific situations in which active cycles may have gone uncounted. The packed field has a mantissa of `MANT_W` bits (default 12) in the low bits and an exponent of `EXP_W` bits (default 4) above it. Large counts therefore lose precision rather than range, and counts past the largest code saturate.

Top module: `cc_elapsed_enc`

## Requirements
- R1: The internal count rises by one on each clock edge at which `active_i` is high and no capture or restart event occurs. It holds when `active_i` is low.
- R2: `cc_o` and `ccv_o` change only on the clock edge at which `xfer_i` is high. They show the captured values from that edge until the next capture.
- R3: `cc_o[MANT_W+EXP_W-1:MANT_W]` is the exponent and `cc_o[MANT_W-1:0]` is the mantissa. A count below 2^MANT_W is captured with exponent 0 and mantissa equal to the count.
- R4: A count whose leading one is at bit p, with p >= MANT_W, is captured with exponent p-MANT_W+1 and mantissa (count >> (exponent-1)) mod 2^MANT_W. The leading one is implied, so the represented value is (2^MANT_W + mantissa) << (exponent-1).
- R5: The internal count saturates at 2^(MANT_W+2^EXP_W-1)-1 and does not wrap. That count is captured as all ones in both fields.
- R6: After a capture, the count restarts from zero. The capture cycle itself is not counted.
- R7: A pulse on `ctl_wr_i` or `clr_i` zeroes the count. Cycles before it are not reported.
- R8: A pulse on `ctl_wr_i` or `clr_i` clears the valid flag, so the next captured record has `ccv_o` = 0.
- R9: A pulse on `inval_i` clears the valid flag but leaves the count running.
- R10: A capture with no clear, control write or invalidate since the previous capture gives `ccv_o` = 1, and sets the flag for later records.
- R11: When `xfer_i` coincides with `ctl_wr_i`, `clr_i` or `inval_i`, the count from before that edge is captured with `ccv_o` = 0. A coinciding write or clear then zeroes the count.
- R12: After reset, `cc_o` is 0, `ccv_o` is 0, the count is zero and the flag is clear, so the first record after reset has `ccv_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| active_i | input | 1 | Recording active: mode enabled and not frozen |
| xfer_i | input | 1 | Qualified transfer strobe, captures the count |
| ctl_wr_i | input | 1 | Recording control register write strobe |
| clr_i | input | 1 | Clear command strobe |
| inval_i | input | 1 | Implementation-specific count invalidate |
| cc_o | output | MANT_W+EXP_W | Packed cycle count {exponent, mantissa} of the last record |
| ccv_o | output | 1 | Valid flag of the last record |

## Verification
A stimulus applied before a clock edge affects the count on that edge. It reaches `cc_o` and `ccv_o` only if `xfer_i` is high on that same edge, because the output registers load at that edge. The bench drives inputs 5 ns after a rising edge and advances its reference model at the next rising edge. It compares both outputs 5 ns after that edge, so each capture is checked in the cycle it becomes visible, and every cycle without a capture is checked as a hold. After reset is released, the two-flop synchroniser delays the release by two edges, and the bench waits for this before its model starts counting.

// File: rtl/cc_elapsed_pkg.sv
package cc_elapsed_pkg;

  // Operation applied to the elapsed-cycle counter in a given cycle
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_INC  = 2'd1,
    CNT_ZERO = 2'd2
  } cnt_op_e;

  // Counter width that exactly covers the largest packed code
  function automatic int cnt_width(input int mant_w, input int exp_w);
    return mant_w + (1 << exp_w) - 1;
  endfunction

endpackage

// File: rtl/cc_event_dec.sv
module cc_event_dec
  import cc_elapsed_pkg::*;
(
  input  logic    active_i,
  input  logic    xfer_i,
  input  logic    ctl_wr_i,
  input  logic    clr_i,
  input  logic    inval_i,
  output cnt_op_e cnt_op_o,
  output logic    capture_o,
  output logic    drop_vld_o
);

  logic restart;

  always_comb begin
    restart    = xfer_i | ctl_wr_i | clr_i;
    capture_o  = xfer_i;
    drop_vld_o = ctl_wr_i | clr_i | inval_i;
    if (restart)       cnt_op_o = CNT_ZERO;
    else if (active_i) cnt_op_o = CNT_INC;
    else               cnt_op_o = CNT_HOLD;
  end

endmodule

// File: rtl/cc_counter.sv
module cc_counter
  import cc_elapsed_pkg::*;
#(
  parameter int CNT_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_op_e          op_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (op_i)
      CNT_ZERO: begin
        cnt_d  = '0;
        cnt_en = 1'b1;
      end
      CNT_INC: begin
        cnt_en = (cnt_q != CNT_MAX);
        cnt_d  = cnt_q + 1'b1;
      end
      default: begin
        cnt_d  = cnt_q;
        cnt_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == CNT_INC && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == CNT_HOLD) |=> $stable(cnt_q)); // R1
  AST_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == CNT_ZERO) |=> cnt_q == '0); // R7
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i != CNT_ZERO && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX); // R5

endmodule

// File: rtl/cc_valid_flag.sv
module cc_valid_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic capture_i,
  input  logic drop_i,
  output logic cap_vld_o
);

  logic vld_q, vld_d, vld_en;

  always_comb begin
    vld_en = capture_i | drop_i;
    vld_d  = ~drop_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vld_q <= 1'b0;
    else if (vld_en) vld_q <= vld_d;
  end

  // Valid value handed to a record captured this cycle
  assign cap_vld_o = vld_q & ~drop_i;

  AST_VLD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    drop_i |=> !vld_q); // R8
  AST_VLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_i && !drop_i) |=> vld_q); // R10

endmodule

// File: rtl/cc_float_enc.sv
module cc_float_enc #(
  parameter int MANT_W = 12,
  parameter int EXP_W  = 4,
  parameter int CNT_W  = 27
) (
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [EXP_W-1:0]  exp_o,
  output logic [MANT_W-1:0] mant_o
);

  localparam int IDX_W = $clog2(CNT_W);

  logic [IDX_W-1:0] lead_idx;
  logic [CNT_W-1:0] shifted;
  int               shamt;

  // Leading-one position, lowest to highest so the top set bit wins
  always_comb begin
    lead_idx = '0;
    for (int i = 0; i < CNT_W; i++) begin
      if (cnt_i[i]) lead_idx = IDX_W'(i);
    end
  end

  always_comb begin
    shamt   = 0;
    shifted = cnt_i;
    exp_o   = '0;
    mant_o  = cnt_i[MANT_W-1:0];
    if (cnt_i[CNT_W-1:MANT_W] != '0) begin
      shamt   = int'(lead_idx) - MANT_W;
      shifted = cnt_i >> shamt;
      exp_o   = EXP_W'(shamt + 1);
      mant_o  = shifted[MANT_W-1:0];
    end
  end

endmodule

// File: rtl/cc_capture.sv
module cc_capture #(
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_i,
  input  logic [OUT_W-1:0] code_i,
  input  logic             vld_i,
  output logic [OUT_W-1:0] code_o,
  output logic             vld_o
);

  logic [OUT_W-1:0] code_q;
  logic             vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      vld_q  <= 1'b0;
    end else if (capture_i) begin
      code_q <= code_i;
      vld_q  <= vld_i;
    end
  end

  assign code_o = code_q;
  assign vld_o  = vld_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_i |=> ($stable(code_q) && $stable(vld_q))); // R2

endmodule

// File: rtl/cc_elapsed_enc.sv
module cc_elapsed_enc
  import cc_elapsed_pkg::*;
#(
  parameter int MANT_W = 12,
  parameter int EXP_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    active_i,
  input  logic                    xfer_i,
  input  logic                    ctl_wr_i,
  input  logic                    clr_i,
  input  logic                    inval_i,
  output logic [MANT_W+EXP_W-1:0] cc_o,
  output logic                    ccv_o
);

  localparam int CNT_W = cnt_width(MANT_W, EXP_W);
  localparam int OUT_W = MANT_W + EXP_W;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  cnt_op_e           cnt_op;
  logic              capture;
  logic              drop_vld;
  logic              cap_vld;
  logic [CNT_W-1:0]  cnt;
  logic [EXP_W-1:0]  enc_exp;
  logic [MANT_W-1:0] enc_mant;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cc_event_dec u_dec (
    .active_i   (active_i),
    .xfer_i     (xfer_i),
    .ctl_wr_i   (ctl_wr_i),
    .clr_i      (clr_i),
    .inval_i    (inval_i),
    .cnt_op_o   (cnt_op),
    .capture_o  (capture),
    .drop_vld_o (drop_vld)
  );

  cc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .op_i  (cnt_op),
    .cnt_o (cnt)
  );

  cc_valid_flag u_vld (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .capture_i (capture),
    .drop_i    (drop_vld),
    .cap_vld_o (cap_vld)
  );

  cc_float_enc #(.MANT_W(MANT_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_enc (
    .cnt_i  (cnt),
    .exp_o  (enc_exp),
    .mant_o (enc_mant)
  );

  cc_capture #(.OUT_W(OUT_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .capture_i (capture),
    .code_i    ({enc_exp, enc_mant}),
    .vld_i     (cap_vld),
    .code_o    (cc_o),
    .vld_o     (ccv_o)
  );

  AST_SAME_CYCLE_KILL: assert property (@(posedge clk) disable iff (!rst_int_n)
    (xfer_i && (ctl_wr_i || clr_i || inval_i)) |=> !ccv_o); // R11
  AST_INVAL_KEEPS_CNT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (inval_i && !xfer_i && !ctl_wr_i && !clr_i && !active_i) |=> $stable(cnt)); // R9
  AST_SMALL_EXP_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (xfer_i && cnt[CNT_W-1:MANT_W] == '0) |=> cc_o[OUT_W-1:MANT_W] == '0); // R3

endmodule

// File: tb/sim_cc_elapsed_enc.sv
module sim_cc_elapsed_enc;

  localparam int MW    = 6;
  localparam int EW    = 3;
  localparam int OW    = MW + EW;
  localparam int CMAX  = (1 << (MW + (1 << EW) - 1)) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          active_i, xfer_i, ctl_wr_i, clr_i, inval_i;
  logic [OW-1:0] cc_o;
  logic          ccv_o;

  int n_chk  = 0;
  int n_fail = 0;

  int          m_cnt;
  logic        m_vld;
  logic [OW-1:0] e_cc;
  logic        e_v;

  always #10 clk = ~clk;

  cc_elapsed_enc #(.MANT_W(MW), .EXP_W(EW)) u0 (
    .clk(clk), .rst_n(rst_n), .active_i(active_i), .xfer_i(xfer_i),
    .ctl_wr_i(ctl_wr_i), .clr_i(clr_i), .inval_i(inval_i),
    .cc_o(cc_o), .ccv_o(ccv_o)
  );

  // Packed code from the requirement text (R3, R4)
  function automatic logic [OW-1:0] f_code(input int c);
    int p, e, m;
    if (c < (1 << MW)) return OW'(c);
    p = 0;
    for (int i = 0; i < 31; i++) if (((c >> i) & 1) == 1) p = i;
    e = p - MW + 1;
    m = (c >> (e - 1)) % (1 << MW);
    return {EW'(e), MW'(m)};
  endfunction

  task automatic check(input string tag, input logic [OW-1:0] xcc, input logic xv);
    n_chk++;
    if (cc_o !== xcc || ccv_o !== xv) begin
      n_fail++;
      $display("FAIL %s: actual cc=%0h v=%0b expected cc=%0h v=%0b",
               tag, cc_o, ccv_o, xcc, xv);
    end
  endtask

  task automatic cyc(input logic a, input logic x, input logic w,
                     input logic c, input logic v);
    string tag;
    logic  kill;
    active_i = a; xfer_i = x; ctl_wr_i = w; clr_i = c; inval_i = v;
    @(posedge clk);
    kill = w | c | v;
    if (x) begin
      e_cc = f_code(m_cnt);
      e_v  = m_vld & ~kill;
    end
    if (x | w | c)            m_cnt = 0;
    else if (a && m_cnt < CMAX) m_cnt++;
    if (kill)   m_vld = 1'b0;
    else if (x) m_vld = 1'b1;
    #5;
    if (x && (w || c))  tag = "R11";
    else if (x && v)    tag = "R9";
    else if (x)         tag = "R2";
    else                tag = "R2 hold";
    check(tag, e_cc, e_v);
  endtask

  task automatic run(input int n, input logic a);
    for (int i = 0; i < n; i++) cyc(a, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250417));
    rst_n = 1'b0;
    active_i = 0; xfer_i = 0; ctl_wr_i = 0; clr_i = 0; inval_i = 0;
    m_cnt = 0; m_vld = 1'b0; e_cc = '0; e_v = 1'b0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #5;
    check("R12 reset", '0, 1'b0);

    // R12 first record invalid, R3 small count
    run(5, 1'b1);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R3 R12", OW'(5), 1'b0);
    // R6 restart after capture, R10 valid
    run(20, 1'b1);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R6 R10", OW'(20), 1'b1);
    // R4 large counts
    run(100, 1'b1);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R4 100", {3'd1, 6'd36}, 1'b1);
    run(200, 1'b1);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R4 200", {3'd2, 6'd36}, 1'b1);
    // R7 R8 control write
    run(10, 1'b1);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    run(3, 1'b1);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R7 R8", OW'(3), 1'b0);
    // R9 invalidate keeps counting
    run(4, 1'b1);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    run(4, 1'b1);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R9", OW'(9), 1'b0);
    // R11 capture with clear in the same cycle
    run(6, 1'b1);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R10", OW'(6), 1'b1);
    run(8, 1'b1);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R11", OW'(8), 1'b0);
    run(2, 1'b1);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R11 R8 after", OW'(2), 1'b0);
    // R1 inactive cycles hold the count
    for (int i = 0; i < 10; i++) cyc(i[0], 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R1", OW'(5), 1'b1);
    // R5 saturation
    run(9000, 1'b1);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R5", {OW{1'b1}}, 1'b1);

    // Constrained random phase checked against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 10) < 7, ($urandom % 20) == 0, ($urandom % 100) == 0,
          ($urandom % 100) == 0, ($urandom % 100) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule